// File: doc/BRIEF.md
# Video PLL Coast and Clamp Strobe Generator

This block sits behind the sync inputs of a video capture front end. It produces two active-high strobes. The first is a coast strobe, which tells the pixel clock PLL to stop tracking horizontal sync. The second is a clamp strobe, which marks the black-level window for the input clamps. Every asynchronous input passes through a two-flop synchronizer before use. Both strobes are registered, except for a final source multiplexer that the configuration fields control.

Coast comes from one of two sources. The first is an external coast pin, with a fixed, forced or self-detected polarity. The second is vertical sync itself, widened on both sides by a programmable number of line periods. To start coast before vertical sync arrives, the block counts the lines in the previous frame. It raises coast once the running line count plus the lead amount passes that total.

Clamp also comes from one of two sources. The first is an internal window, timed in clocks from the trailing edge of each horizontal sync pulse. The second is an external clamp pin with selectable polarity.

Top module: `coast_clamp_ctrl`

## Requirements
- R1: While rst_ni is low, and until the synchronized inputs act after release, coast_o and clamp_o are 0.
- R2: A level change on an asynchronous input that is present at clock edge k is first used by the logic clocked at edge k+2. A registered strobe that follows a pin therefore changes just after edge k+2.
- R3: coast_sel_i = 0 makes coast_o the pin-derived coast. coast_sel_i = 1 makes it the vertical-sync-derived coast. The lead and trail counts have no effect on coast_o while coast_sel_i = 0.
- R4: With coast_pol_ovr_i = 1, the pin is active high when coast_pol_i = 1 and active low when coast_pol_i = 0.
- R5: With coast_pol_ovr_i = 0, coast_pol_i is ignored and the pin polarity is detected. The detected polarity starts as active high. At each vertical sync rising edge it becomes active low if the pin was high on more than half of the clocks since the previous rising edge, and active high otherwise.
- R6: In vertical-sync mode, every clock with vertical sync high is followed by a coast_o of 1 on the next clock. Vertical sync is active high.
- R7: After the falling edge of vertical sync, coast_o stays 1 until post_coast_i horizontal sync rising edges have been counted. It drops on the clock after the last of them. With post_coast_i = 0 it drops on the clock after the falling edge.
- R8: When pre_coast_i is nonzero and at least one whole frame has been measured, coast_o rises once the running line count plus pre_coast_i exceeds the line count of the last frame. A lead larger than the frame keeps coast on for the whole frame. pre_coast_i = 0 gives no lead.
- R9: With clamp_sel_i = 0, clamp_pol_i is ignored. Suppose a horizontal sync falling edge is present at edge m. Then clamp_o is 1 just after edges m+CLAMP_DLY+2 through m+CLAMP_DLY+CLAMP_LEN+1. Another falling edge restarts this timing.
- R10: With clamp_sel_i = 1, clamp_o follows the clamp pin with the R2 latency. clamp_pol_i = 0 means active high and 1 means active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync, active high, asynchronous |
| vsync_i | input | 1 | Vertical sync, active high, asynchronous |
| coast_pin_i | input | 1 | External coast request, asynchronous |
| clamp_pin_i | input | 1 | External clamp request, asynchronous |
| coast_sel_i | input | 1 | 0 = coast pin source, 1 = vertical sync source |
| coast_pol_ovr_i | input | 1 | 1 = coast_pol_i sets pin polarity, 0 = detected |
| coast_pol_i | input | 1 | Forced pin polarity, 1 = active high |
| pre_coast_i | input | PRE_W | Lead in lines before vertical sync |
| post_coast_i | input | PRE_W | Trail in lines after vertical sync |
| clamp_sel_i | input | 1 | 0 = internal clamp window, 1 = clamp pin |
| clamp_pol_i | input | 1 | Clamp pin polarity, 0 = active high |
| coast_o | output | 1 | Coast strobe, active high |
| clamp_o | output | 1 | Clamp strobe, active high |

## Verification
The assertions assume that horizontal and vertical sync never change within the same synchronized cycle. When they do, the load of the line counter and of the trail counter takes priority over counting an edge. To respect this, the stimulus places every vertical sync transition half a line away from the horizontal sync edges. The configuration fields are treated as quasi-static: the bench changes them only at phase boundaries, between falling clock edges. Each phase runs long enough for a whole frame to be measured before the lead behaviour is compared.

// File: rtl/coast_clamp_pkg.sv
package coast_clamp_pkg;
  localparam int SIG_HS    = 0;
  localparam int SIG_VS    = 1;
  localparam int SIG_COAST = 2;
  localparam int SIG_CLAMP = 3;
  localparam int NUM_SIG   = 4;
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q, d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      d_q  <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      d_q  <= s2_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign rise_o[i] = s2_q[i] & ~d_q[i];
    assign fall_o[i] = ~s2_q[i] & d_q[i];
  end

  assign lvl_o = s2_q;
endmodule

// File: rtl/cc_coast_pol.sv
module cc_coast_pol #(
  parameter int FRAME_W = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_lvl_i,
  input  logic vs_rise_i,
  input  logic ovr_i,
  input  logic pol_i,
  output logic coast_o
);
  localparam logic [FRAME_W-1:0] CNT_MAX = '1;

  logic [FRAME_W-1:0] hi_q, cyc_q;
  logic               act_hi_q;
  logic               coast_q;
  logic               act_hi;

  assign act_hi = ovr_i ? pol_i : act_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q     <= '0;
      cyc_q    <= '0;
      act_hi_q <= 1'b1;
      coast_q  <= 1'b0;
    end else begin
      coast_q <= act_hi ? pin_lvl_i : ~pin_lvl_i;
      if (vs_rise_i) begin
        // majority high over the frame -> pin idles high -> active low
        act_hi_q <= ({hi_q, 1'b0} <= {1'b0, cyc_q});
        hi_q     <= '0;
        cyc_q    <= '0;
      end else begin
        if (cyc_q != CNT_MAX) cyc_q <= cyc_q + FRAME_W'(1);
        if (pin_lvl_i && hi_q != CNT_MAX) hi_q <= hi_q + FRAME_W'(1);
      end
    end
  end

  assign coast_o = coast_q;

  AST_POL_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && pol_i && pin_lvl_i) |=> coast_o); // R4
endmodule

// File: rtl/cc_coast_vs.sv
module cc_coast_vs #(
  parameter int LINE_W = 12,
  parameter int PRE_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vs_lvl_i,
  input  logic             vs_rise_i,
  input  logic             vs_fall_i,
  input  logic             hs_rise_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [PRE_W-1:0] post_i,
  output logic             coast_o
);
  localparam int SUM_W = ((LINE_W > PRE_W) ? LINE_W : PRE_W) + 1;
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_q, total_q;
  logic              seen_q, valid_q;
  logic [PRE_W-1:0]  post_q;
  logic              coast_q;
  logic              pre_hit;

  assign pre_hit = valid_q && (pre_i != '0) &&
                   ((SUM_W'(line_q) + SUM_W'(pre_i)) > SUM_W'(total_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      total_q <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
      post_q  <= '0;
      coast_q <= 1'b0;
    end else begin
      coast_q <= vs_lvl_i | vs_fall_i | (post_q != '0) | pre_hit;
      if (vs_fall_i)                    post_q <= post_i;
      else if (hs_rise_i && post_q != '0) post_q <= post_q - PRE_W'(1);
      if (vs_rise_i) begin
        total_q <= line_q;
        valid_q <= seen_q;
        seen_q  <= 1'b1;
        line_q  <= '0;
      end else if (hs_rise_i && line_q != LINE_MAX) begin
        line_q <= line_q + LINE_W'(1);
      end
    end
  end

  assign coast_o = coast_q;

  AST_VS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_lvl_i |=> coast_o); // R6
  AST_POST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vs_fall_i |=> coast_o); // R7
  AST_PRE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i == '0 && !vs_lvl_i && !vs_fall_i && post_q == '0) |=> !coast_o); // R8
endmodule

// File: rtl/cc_clamp_gen.sv
module cc_clamp_gen #(
  parameter int CLAMP_DLY = 4,
  parameter int CLAMP_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hs_fall_i,
  input  logic pin_lvl_i,
  input  logic sel_i,
  input  logic pol_i,
  output logic clamp_o
);
  localparam int T_W = $clog2(CLAMP_DLY + CLAMP_LEN + 1);
  localparam logic [T_W-1:0] T_ON  = T_W'(CLAMP_DLY);
  localparam logic [T_W-1:0] T_END = T_W'(CLAMP_DLY + CLAMP_LEN);

  logic [T_W-1:0] t_q;
  logic           ext_q;
  logic           int_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q   <= '0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= pol_i ? ~pin_lvl_i : pin_lvl_i;
      if (hs_fall_i)        t_q <= T_W'(1);
      else if (t_q == T_END) t_q <= '0;
      else if (t_q != '0)    t_q <= t_q + T_W'(1);
    end
  end

  assign int_win = (t_q > T_ON) && (t_q <= T_END);
  assign clamp_o = sel_i ? ext_q : int_win;

  if (CLAMP_DLY > 0) begin : g_gap_chk
    AST_CLAMP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hs_fall_i |=> !int_win); // R9
  end
endmodule

// File: rtl/coast_clamp_ctrl.sv
module coast_clamp_ctrl
  import coast_clamp_pkg::*;
#(
  parameter int LINE_W    = 12,
  parameter int FRAME_W   = 20,
  parameter int PRE_W     = 8,
  parameter int CLAMP_DLY = 4,
  parameter int CLAMP_LEN = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             coast_pin_i,
  input  logic             clamp_pin_i,
  input  logic             coast_sel_i,
  input  logic             coast_pol_ovr_i,
  input  logic             coast_pol_i,
  input  logic [PRE_W-1:0] pre_coast_i,
  input  logic [PRE_W-1:0] post_coast_i,
  input  logic             clamp_sel_i,
  input  logic             clamp_pol_i,
  output logic             coast_o,
  output logic             clamp_o
);
  logic [NUM_SIG-1:0] raw, lvl, rise, fall;
  logic               pin_coast, vs_coast;

  always_comb begin
    raw            = '0;
    raw[SIG_HS]    = hsync_i;
    raw[SIG_VS]    = vsync_i;
    raw[SIG_COAST] = coast_pin_i;
    raw[SIG_CLAMP] = clamp_pin_i;
  end

  cc_sync_edge #(.W(NUM_SIG)) u_sync (
    .clk_i, .rst_ni, .async_i(raw), .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  cc_coast_pol #(.FRAME_W(FRAME_W)) u_pol (
    .clk_i, .rst_ni,
    .pin_lvl_i(lvl[SIG_COAST]), .vs_rise_i(rise[SIG_VS]),
    .ovr_i(coast_pol_ovr_i), .pol_i(coast_pol_i), .coast_o(pin_coast)
  );

  cc_coast_vs #(.LINE_W(LINE_W), .PRE_W(PRE_W)) u_vs (
    .clk_i, .rst_ni,
    .vs_lvl_i(lvl[SIG_VS]), .vs_rise_i(rise[SIG_VS]), .vs_fall_i(fall[SIG_VS]),
    .hs_rise_i(rise[SIG_HS]), .pre_i(pre_coast_i), .post_i(post_coast_i),
    .coast_o(vs_coast)
  );

  cc_clamp_gen #(.CLAMP_DLY(CLAMP_DLY), .CLAMP_LEN(CLAMP_LEN)) u_clamp (
    .clk_i, .rst_ni,
    .hs_fall_i(fall[SIG_HS]), .pin_lvl_i(lvl[SIG_CLAMP]),
    .sel_i(clamp_sel_i), .pol_i(clamp_pol_i), .clamp_o(clamp_o)
  );

  assign coast_o = coast_sel_i ? vs_coast : pin_coast;
endmodule

// File: tb/coast_clamp_ctrl_bench.sv
module coast_clamp_ctrl_bench;
  localparam int DLY = 4;
  localparam int LEN = 6;
  localparam int FMAX = (1 << 20) - 1;
  localparam int LMAX = (1 << 12) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 0, vs = 0, cp = 0, cl = 0;
  logic c_sel = 0, c_ovr = 1, c_pol = 1, k_sel = 0, k_pol = 0;
  logic [7:0] pre = 0, post = 0;
  logic coast_o, clamp_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string req_c = "R1", req_k = "R1";

  always #4 clk = ~clk;

  coast_clamp_ctrl #(.LINE_W(12), .FRAME_W(20), .PRE_W(8),
                     .CLAMP_DLY(DLY), .CLAMP_LEN(LEN)) u_coast_clamp_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs),
    .coast_pin_i(cp), .clamp_pin_i(cl), .coast_sel_i(c_sel),
    .coast_pol_ovr_i(c_ovr), .coast_pol_i(c_pol),
    .pre_coast_i(pre), .post_coast_i(post),
    .clamp_sel_i(k_sel), .clamp_pol_i(k_pol),
    .coast_o(coast_o), .clamp_o(clamp_o)
  );

  // reference model: inputs seen through a 3-deep history queue
  bit h1 [4], h2 [4], h3 [4];
  bit m_cp = 0, m_det = 1, m_cv = 0, m_ce = 0, m_seen = 0, m_valid = 0;
  int m_hi = 0, m_cyc = 0, m_line = 0, m_total = 0, m_post = 0, m_t = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (h1[i]) begin h1[i] = 0; h2[i] = 0; h3[i] = 0; end
      m_cp = 0; m_det = 1; m_cv = 0; m_ce = 0; m_seen = 0; m_valid = 0;
      m_hi = 0; m_cyc = 0; m_line = 0; m_total = 0; m_post = 0; m_t = 0;
    end else begin
      bit hr, hf, vr, vf, ah, ph;
      hr = h2[0] && !h3[0]; hf = !h2[0] && h3[0];
      vr = h2[1] && !h3[1]; vf = !h2[1] && h3[1];
      ah = c_ovr ? c_pol : m_det;
      m_cp = ah ? h2[2] : !h2[2];
      if (vr) begin
        m_det = !(2 * m_hi > m_cyc); m_hi = 0; m_cyc = 0;
      end else begin
        if (m_cyc < FMAX) m_cyc++;
        if (h2[2] && m_hi < FMAX) m_hi++;
      end
      ph = m_valid && pre != 0 && (m_line + pre > m_total);
      m_cv = h2[1] || vf || m_post != 0 || ph;
      if (vf) m_post = post;
      else if (hr && m_post > 0) m_post--;
      if (vr) begin
        m_total = m_line; m_valid = m_seen; m_seen = 1; m_line = 0;
      end else if (hr && m_line < LMAX) m_line++;
      m_ce = k_pol ? !h2[3] : h2[3];
      if (hf) m_t = 1;
      else if (m_t == DLY + LEN) m_t = 0;
      else if (m_t != 0) m_t++;
      foreach (h1[i]) begin h3[i] = h2[i]; h2[i] = h1[i]; end
      h1[0] = hs; h1[1] = vs; h1[2] = cp; h1[3] = cl;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(coast_o, c_sel ? m_cv : m_cp, req_c, "coast_o");
    chk(clamp_o, k_sel ? m_ce : (m_t > DLY && m_t <= DLY + LEN), req_k, "clamp_o");
  endtask

  logic [15:0] lfsr = 16'hACE1;
  int pos = 0;

  task automatic run(input int cycles, input int hper, input int hhi,
                     input int nlines, input int vsl, input int bias);
    for (int n = 0; n < cycles; n++) begin
      int vp;
      tick();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hs = (pos % hper) < hhi;
      vp = pos - hper / 2;
      vs = (vp >= 0) && (((vp / hper) % nlines) < vsl);
      if (pos % 8 == 0) cp = (int'(lfsr[3:0]) < bias);
      if (pos % 5 == 0) cl = lfsr[7];
      pos++;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(coast_o, 1'b0, "R1", "coast_o in reset");
      chk(clamp_o, 1'b0, "R1", "clamp_o in reset");
    end
    rst_n = 1'b1;
    repeat (4) tick();

    // R2: pin latency, forced active high
    req_c = "R2"; req_k = "R9";
    cp = 0; repeat (4) tick();
    cp = 1;
    tick(); chk(coast_o, 1'b0, "R2", "coast_o edge k");
    tick(); chk(coast_o, 1'b0, "R2", "coast_o edge k+1");
    tick(); chk(coast_o, 1'b1, "R2", "coast_o edge k+2");

    // R3/R4: pin source, lead/trail set but ignored
    req_c = "R3"; pre = 8'd5; post = 8'd3;
    run(1500, 40, 6, 20, 3, 6);
    req_c = "R4"; c_pol = 0; k_pol = 1;   // clamp polarity ignored (R9)
    run(1500, 40, 6, 20, 3, 6);

    // R5: detected polarity, forced bit toggled and ignored
    req_c = "R5"; c_ovr = 0; c_pol = 1;
    run(3000, 40, 6, 20, 3, 13);
    c_pol = 0;
    run(3000, 40, 6, 20, 3, 3);

    // R6: vsync source without lead or trail
    req_c = "R6"; c_sel = 1; pre = 0; post = 0;
    run(2500, 40, 6, 20, 3, 8);
    // R7: trail
    req_c = "R7"; post = 8'd3;
    run(2500, 40, 6, 20, 3, 8);
    // R8: lead, then lead larger than frame, then frame length change
    req_c = "R8"; post = 0; pre = 8'd2;
    run(3000, 40, 6, 20, 3, 8);
    pre = 8'd200;
    run(2500, 40, 6, 20, 3, 8);
    pre = 8'd3; post = 8'd1;
    run(3000, 40, 6, 16, 2, 8);

    // R9: clamp retrigger with short lines
    req_k = "R9";
    run(1500, 8, 3, 30, 4, 8);
    // R10: external clamp, both polarities
    req_k = "R10"; k_sel = 1; k_pol = 0;
    run(1000, 40, 6, 20, 3, 8);
    k_pol = 1;
    run(1000, 40, 6, 20, 3, 8);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule